// File: doc/BRIEF.md
# SPI Word Master Shift Engine

This block is a single-lane SPI master that moves 32-bit words. It takes one word at a time from a transmit queue through a valid/ready handshake and shifts it out on MOSI, most significant bit first. In the same bit slots it collects MISO into a receive word, which it presents with a one-cycle strobe. The serial clock is the reference clock divided by a power of two picked by a 3-bit code. Clock polarity and clock phase are both selectable.

Four 8-bit gap settings, counted in reference-clock cycles, shape the timing around each word. The lead gap runs from chip-select assertion to the first bit. The word gap runs between two words that share one chip-select assertion (CPHA = 1). The release gap is the time chip select goes high between words when CPHA = 0. The rest gap is the idle time after the last word before chip select may assert again. Software can drive chip select by hand. It can also hold transfers back until a one-shot start command arrives. A global enable gates the whole engine.

Top module: `spi_word_master`

## Requirements
- R1: Divider code c (0..7) gives a bit period of D = 2^(c+1) reference cycles. For a single word, chip select stays low for Llead + 32·D cycles.
- R2: While idle, SCLK rests at the CPOL level. With CPHA = 0 the first SCLK change comes Llead + D/2 cycles after chip select falls, and MISO is sampled on the leading edge. With CPHA = 1 the first change comes Llead cycles after the fall, and MISO is sampled on the trailing edge.
- R3: MOSI carries the accepted word MSB first. The word collected from MISO, first bit as MSB, appears on rx_word while rx_valid is high for exactly one cycle after the 32nd bit.
- R4: After chip select falls, shifting starts once Llead cycles have passed, where Llead is the lead gap setting.
- R5: With CPHA = 1 and a word waiting when the current word ends, chip select stays low. The next word starts after a word gap of Lword cycles, so two words give one low period of 2·Llead-free length Llead + 64·D + Lword.
- R6: With CPHA = 0 and a word waiting, chip select goes high for exactly Lrel cycles (the release gap). It then falls again, and the lead gap comes before the next word.
- R7: After the last word, chip select stays high for the rest gap Lrest and then one idle cycle before a waiting word can assert it again. The high time is Lrest + 1 cycles.
- R8: A gap setting of 0 acts as 1 cycle, so every L above equals max(setting, 1).
- R9: When cs_manual = 1, cs_n equals cs_manual_level at all times, whatever the sequencer is doing.
- R10: When start_gate_en = 1, an idle engine accepts no word until a start_cmd pulse has arrived. Each pulse allows one burst. A burst runs until the queue is empty, and a later word then needs a new pulse.
- R11: When en = 0, no word is accepted. A transfer already running is dropped on the next clock edge: chip select goes high, SCLK returns to CPOL, and no rx_valid is produced for that word.
- R12: During and right after reset, with en = 0, the outputs are cs_n = 1, SCLK = CPOL, MOSI = 0, rx_valid = 0 and tx_ready = 0.
- R13: A word is taken when tx_valid and tx_ready are both high. tx_ready is high only when the engine is idle and allowed to start, or in the last cycle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global engine enable |
| clk_div_sel | input | 3 | Divider code, D = 2^(code+1) |
| cpol | input | 1 | SCLK idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cs_manual | input | 1 | 1: cs_n follows cs_manual_level |
| cs_manual_level | input | 1 | Level driven on cs_n in manual mode |
| start_gate_en | input | 1 | Require start_cmd before a burst |
| start_cmd | input | 1 | One-shot start pulse |
| dly_lead | input | 8 | Cycles from chip-select fall to first bit |
| dly_word_gap | input | 8 | Cycles between words under one assertion (CPHA = 1) |
| dly_cs_off | input | 8 | Chip-select high time between words (CPHA = 0) |
| dly_cs_rest | input | 8 | Chip-select high time after a burst |
| tx_valid | input | 1 | Transmit word available |
| tx_word | input | 32 | Transmit word |
| tx_ready | output | 1 | Engine takes the word this cycle if tx_valid |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| rx_valid | output | 1 | One-cycle received-word strobe |
| rx_word | output | 32 | Received word |

## Verification
The hardest case to reach is the back-to-back path. tx_valid must already be high for the next word in the exact cycle the 32nd bit ends, or the sequencer falls into the rest gap instead of the word gap or release gap. The bench handles this by presenting the second word as soon as the first has been taken and holding it until tx_ready appears at the end of the word. A slave model follows the SCLK edges on each side to produce MISO and collect MOSI. A second hard case is the divide-by-2 setting, where the MISO sample and the end of the bit fall in the same cycle. The bench runs zero gap settings at that divider to cover it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,      // chip select high, waiting for a word
    ST_LEAD,      // chip select low, lead gap before first bit
    ST_SHIFT,     // bits moving
    ST_GAP_LOW,   // word gap, chip select held low
    ST_GAP_HIGH,  // release gap, chip select high between words
    ST_REST       // rest gap after the last word
  } seq_state_e;

  // Bit period in reference cycles for a divider code.
  function automatic int unsigned bit_period(input int unsigned code);
    return 32'd2 << code;
  endfunction

  // Effective gap length: zero is stretched to one cycle.
  function automatic int unsigned gap_cycles(input int unsigned setting);
    return (setting == 0) ? 32'd1 : setting;
  endfunction

endpackage

// File: rtl/spi_bit_timer.sv
module spi_bit_timer #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             sample_tick,
  output logic             bit_end,
  output logic             word_end,
  output logic             second_half
);
  import spi_eng_pkg::*;

  localparam int CNT_W = 2 ** DIV_W;
  localparam int BIT_W = $clog2(WORD_W);

  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bit_idx;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] half_cnt;

  always_comb begin
    period   = (CNT_W+1)'(bit_period(32'(div_sel)));
    last_cnt = CNT_W'(period - 1'b1);
    half_cnt = CNT_W'(period >> 1);
  end

  assign sample_tick = run && (cnt == half_cnt);
  assign bit_end     = run && (cnt == last_cnt);
  assign word_end    = bit_end && (bit_idx == BIT_W'(WORD_W - 1));
  assign second_half = cnt >= half_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt     <= '0;
      bit_idx <= '0;
    end else if (bit_end) begin
      cnt     <= '0;
      bit_idx <= bit_idx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Sampling happens once per bit, so two sample ticks are never adjacent.
  assert_sample_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              sample_tick,
  input  logic              bit_end,
  input  logic              word_end,
  input  logic              miso,
  output logic              mosi_bit,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] rx_next;

  // At divide-by-2 the last sample and the word end share one cycle.
  assign rx_next  = sample_tick ? {rx_sh[WORD_W-2:0], miso} : rx_sh;
  assign mosi_bit = tx_sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_word  <= '0;
    end else begin
      if (load)                      tx_sh <= load_word;
      else if (bit_end && !word_end) tx_sh <= tx_sh << 1;
      rx_sh    <= rx_next;
      rx_valid <= word_end;
      if (word_end) rx_word <= rx_next;
    end
  end

  assert_rx_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cpha,
  input  logic             start_gate_en,
  input  logic             start_cmd,
  input  logic             tx_valid,
  input  logic             word_end,
  input  logic [GAP_W-1:0] dly_lead,
  input  logic [GAP_W-1:0] dly_word_gap,
  input  logic [GAP_W-1:0] dly_cs_off,
  input  logic [GAP_W-1:0] dly_cs_rest,
  output logic             tx_ready,
  output logic             accept,
  output logic             shift_run,
  output logic             cs_auto_n
);
  import spi_eng_pkg::*;

  seq_state_e       state, nxt;
  logic [GAP_W-1:0] gcnt;
  logic [GAP_W-1:0] cur_dly;
  logic             gap_done;
  logic             armed;
  logic             start_ok;

  assign start_ok  = !start_gate_en || armed;
  assign tx_ready  = en && (((state == ST_IDLE) && start_ok) || word_end);
  assign accept    = tx_ready && tx_valid;
  assign shift_run = (state == ST_SHIFT);
  assign cs_auto_n = !((state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_GAP_LOW));

  always_comb begin
    case (state)
      ST_LEAD:     cur_dly = dly_lead;
      ST_GAP_LOW:  cur_dly = dly_word_gap;
      ST_GAP_HIGH: cur_dly = dly_cs_off;
      default:     cur_dly = dly_cs_rest;
    endcase
    gap_done = (32'(gcnt) + 32'd1) >= gap_cycles(32'(cur_dly));
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (accept) nxt = ST_LEAD;
      ST_LEAD:     if (gap_done) nxt = ST_SHIFT;
      ST_SHIFT:    if (word_end) nxt = accept ? (cpha ? ST_GAP_LOW : ST_GAP_HIGH) : ST_REST;
      ST_GAP_LOW:  if (gap_done) nxt = ST_SHIFT;
      ST_GAP_HIGH: if (gap_done) nxt = ST_LEAD;
      ST_REST:     if (gap_done) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state <= ST_IDLE;
      gcnt  <= '0;
      armed <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state || state == ST_IDLE || state == ST_SHIFT) gcnt <= '0;
      else                                                      gcnt <= gcnt + 1'b1;
      if (accept && state == ST_IDLE) armed <= 1'b0;
      else if (start_cmd)             armed <= 1'b1;
    end
  end

  assert_disable_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE));

  assert_start_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_gate_en && !armed) |-> !tx_ready);

  assert_shift_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_run && !$past(shift_run)) |-> ($past(state) == ST_LEAD || $past(state) == ST_GAP_LOW));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 3,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  clk_div_sel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              cs_manual,
  input  logic              cs_manual_level,
  input  logic              start_gate_en,
  input  logic              start_cmd,
  input  logic [GAP_W-1:0]  dly_lead,
  input  logic [GAP_W-1:0]  dly_word_gap,
  input  logic [GAP_W-1:0]  dly_cs_off,
  input  logic [GAP_W-1:0]  dly_cs_rest,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_ready,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word
);
  logic accept, shift_run, cs_auto_n;
  logic sample_tick, bit_end, word_end, second_half;
  logic mosi_bit;

  spi_seq_ctrl #(.GAP_W(GAP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .cpha(cpha),
    .start_gate_en(start_gate_en), .start_cmd(start_cmd),
    .tx_valid(tx_valid), .word_end(word_end),
    .dly_lead(dly_lead), .dly_word_gap(dly_word_gap),
    .dly_cs_off(dly_cs_off), .dly_cs_rest(dly_cs_rest),
    .tx_ready(tx_ready), .accept(accept),
    .shift_run(shift_run), .cs_auto_n(cs_auto_n)
  );

  spi_bit_timer #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(shift_run), .div_sel(clk_div_sel),
    .sample_tick(sample_tick), .bit_end(bit_end),
    .word_end(word_end), .second_half(second_half)
  );

  spi_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_word(tx_word),
    .sample_tick(sample_tick), .bit_end(bit_end), .word_end(word_end),
    .miso(miso), .mosi_bit(mosi_bit), .rx_valid(rx_valid), .rx_word(rx_word)
  );

  // CPHA=0: active level in the second half of a bit; CPHA=1: in the first half.
  assign sclk = cpol ^ (shift_run & (cpha ? !second_half : second_half));
  assign mosi = shift_run & mosi_bit;
  assign cs_n = cs_manual ? cs_manual_level : cs_auto_n;

endmodule

// File: tb/tb_spi_word_master.sv
module tb_spi_word_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic en, cpol, cpha, cs_manual, cs_manual_level, start_gate_en, start_cmd;
  logic [2:0] clk_div_sel;
  logic [7:0] dly_lead, dly_word_gap, dly_cs_off, dly_cs_rest;
  logic tx_valid, tx_ready, miso, sclk, mosi, cs_n, rx_valid;
  logic [31:0] tx_word, rx_word;

  spi_word_master dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_div_sel(clk_div_sel),
    .cpol(cpol), .cpha(cpha), .cs_manual(cs_manual), .cs_manual_level(cs_manual_level),
    .start_gate_en(start_gate_en), .start_cmd(start_cmd),
    .dly_lead(dly_lead), .dly_word_gap(dly_word_gap),
    .dly_cs_off(dly_cs_off), .dly_cs_rest(dly_cs_rest),
    .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .rx_valid(rx_valid), .rx_word(rx_word)
  );

  int checks = 0, failures = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- monitor and slave model (negedge sampling) ----------------
  int cyc = 0, t_fall = 0, t_rise = 0, first_off = -1;
  int low_len[8], high_len[8];
  int nlow = 0, nhigh = 0, nfall = 0, rn = 0;
  int k = 0, wi = 0, mk = 0, mi = 0;
  bit seen_rise = 0, want_first = 0, rx_wide = 0, prev_rxv = 0, lead_e, trail_e;
  logic p_cs = 1'b1, p_sclk = 1'b0;
  logic [31:0] sw[4], mcap[4], rcap[4];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      lead_e  = !p_cs && (sclk !== p_sclk) && (sclk != cpol);
      trail_e = !p_cs && (sclk !== p_sclk) && (sclk == cpol);
      if (p_cs && !cs_n) begin
        nfall++; t_fall = cyc; want_first = 1;
        if (seen_rise && nhigh < 8) begin high_len[nhigh] = cyc - t_rise; nhigh++; end
        if (!cpha && wi < 4) begin miso = sw[wi][31]; k = 1; end
      end
      if (!p_cs && cs_n) begin
        t_rise = cyc; seen_rise = 1;
        if (nlow < 8) begin low_len[nlow] = cyc - t_fall; nlow++; end
        if (!cpha) wi++;
      end
      if (want_first && !cs_n && sclk != cpol) begin first_off = cyc - t_fall; want_first = 0; end
      if ((cpha ? trail_e : lead_e) && mi < 4) begin
        mcap[mi] = {mcap[mi][30:0], mosi}; mk++;
        if (mk == 32) begin mk = 0; mi++; end
      end
      if (!cpha && trail_e && k < 32 && wi < 4) begin miso = sw[wi][31-k]; k++; end
      if (cpha && lead_e && wi < 4) begin
        miso = sw[wi][31-k]; k++;
        if (k == 32) begin k = 0; wi++; end
      end
      if (rx_valid) begin
        if (rn < 4) rcap[rn] = rx_word;
        rn++;
        if (prev_rxv) rx_wide = 1;
      end
    end
    prev_rxv = rx_valid;
    p_cs = cs_n; p_sclk = sclk;
  endtask_placeholder_guard: begin end
  end

  task automatic clear_mon();
    nlow = 0; nhigh = 0; nfall = 0; rn = 0; k = 0; wi = 0; mk = 0; mi = 0;
    seen_rise = 0; want_first = 0; rx_wide = 0; first_off = -1;
    for (int i = 0; i < 4; i++) begin mcap[i] = '0; rcap[i] = '0; end
  endtask

  task automatic cfg(input logic [2:0] dv, input logic pol, input logic pha,
                     input int ld, input int wg, input int off, input int rest);
    @(negedge clk);
    clk_div_sel = dv; cpol = pol; cpha = pha;
    dly_lead = 8'(ld); dly_word_gap = 8'(wg); dly_cs_off = 8'(off); dly_cs_rest = 8'(rest);
    repeat (2) @(negedge clk);
    #1 clear_mon();
  endtask

  // Present a word and return just before the edge that takes it.
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    tx_word = w; tx_valid = 1'b1;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
  endtask

  task automatic drop_tx();
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    int g = 0;
    while ((rn < n || !cs_n) && g < 30000) begin @(negedge clk); g++; end
    repeat (270) @(negedge clk);
    #1;
  endtask

  task automatic wait_cs(input logic lvl);
    int g = 0;
    while (cs_n !== lvl && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R12", "cs_n in reset", cs_n, 1);
    chk("R12", "sclk in reset", sclk, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R12", "cs_n after reset", cs_n, 1);
    chk("R12", "rx_valid after reset", rx_valid, 0);
    chk("R12", "tx_ready with en=0", tx_ready, 0);
    chk("R12", "mosi after reset", mosi, 0);
  endtask

  task automatic t_mode0();
    en = 1'b1;
    cfg(3'd0, 1'b0, 1'b0, 3, 0, 0, 2);
    sw[0] = 32'hA5C3_0F96;
    send(32'h8123_4E7F);
    @(negedge clk); tx_valid = 1'b0; #1;
    chk("R13", "tx_ready low during lead gap", tx_ready, 0);
    wait_done(1);
    chk("R3", "rx count mode0", rn, 1);
    chk("R3", "rx word mode0", rcap[0], 32'hA5C3_0F96);
    chk("R3", "mosi word MSB first", mcap[0], 32'h8123_4E7F);
    chk("R3", "rx_valid width", rx_wide, 0);
    chk("R1", "cs low length D=2 lead=3", low_len[0], 3 + 64);
    chk("R2", "first edge offset cpha0", first_off, 3 + 1);
  endtask

  task automatic t_mode3_b2b();
    cfg(3'd1, 1'b1, 1'b1, 2, 5, 0, 2);
    #1 chk("R2", "idle sclk at cpol=1", sclk, 1);
    sw[0] = 32'h1357_9BDF; sw[1] = 32'hFEDC_0123;
    send(32'h0F0F_3C3C);
    send(32'hC001_D00D);
    drop_tx();
    wait_done(2);
    chk("R5", "single cs low period", nlow, 1);
    chk("R5", "cs low length with word gap", low_len[0], 2 + 128 + 5 + 128);
    chk("R2", "first edge offset cpha1", first_off, 2);
    chk("R3", "rx word0 mode3", rcap[0], 32'h1357_9BDF);
    chk("R3", "rx word1 mode3", rcap[1], 32'hFEDC_0123);
    chk("R3", "mosi word0 mode3", mcap[0], 32'h0F0F_3C3C);
    chk("R3", "mosi word1 mode3", mcap[1], 32'hC001_D00D);
  endtask

  task automatic t_release();
    cfg(3'd3, 1'b0, 1'b0, 1, 0, 4, 3);
    sw[0] = 32'h6B6B_0001; sw[1] = 32'h8000_00FF;
    send(32'h2468_ACE0);
    send(32'h9999_6666);
    drop_tx();
    wait_done(2);
    chk("R6", "cs falls per word", nfall, 2);
    chk("R6", "release gap high time", high_len[0], 4);
    chk("R1", "cs low length D=16", low_len[0], 1 + 512);
    chk("R6", "second word relead", low_len[1], 1 + 512);
    chk("R3", "rx word1 after release", rcap[1], 32'h8000_00FF);
  endtask

  task automatic t_rest();
    cfg(3'd0, 1'b0, 1'b1, 1, 0, 0, 6);
    sw[0] = 32'h0000_FFFF; sw[1] = 32'h5A5A_A5A5;
    send(32'h1111_2222);
    drop_tx();
    wait_cs(1'b0); wait_cs(1'b1);
    tx_word = 32'h3333_4444; tx_valid = 1'b1;
    #1; while (!tx_ready) begin @(negedge clk); #1; end
    drop_tx();
    wait_done(2);
    chk("R7", "rest gap high time", high_len[0], 6 + 1);
    chk("R7", "second burst rx", rcap[1], 32'h5A5A_A5A5);
  endtask

  task automatic t_zero();
    cfg(3'd0, 1'b0, 1'b1, 0, 0, 0, 0);
    sw[0] = 32'hDEAD_BEEF; sw[1] = 32'h0BAD_F00D; sw[2] = 32'h7777_0000;
    send(32'hAAAA_5555);
    send(32'h0123_4567);
    drop_tx();
    wait_cs(1'b0); wait_cs(1'b1);
    tx_word = 32'h89AB_CDEF; tx_valid = 1'b1;
    #1; while (!tx_ready) begin @(negedge clk); #1; end
    drop_tx();
    wait_done(3);
    chk("R8", "zero lead acts as 1", first_off, 1);
    chk("R8", "zero word gap acts as 1", low_len[0], 1 + 64 + 1 + 64);
    chk("R8", "zero rest gap acts as 1", high_len[0], 2);
    chk("R3", "rx word2 at D=2", rcap[2], 32'h7777_0000);
  endtask

  task automatic t_slow();
    cfg(3'd7, 1'b0, 1'b0, 1, 0, 0, 1);
    sw[0] = 32'hC3C3_1E1E;
    send(32'h4000_0001);
    drop_tx();
    wait_done(1);
    chk("R1", "cs low length D=256", low_len[0], 1 + 8192);
    chk("R3", "rx word D=256", rcap[0], 32'hC3C3_1E1E);
  endtask

  task automatic t_manual_cs();
    cfg(3'd0, 1'b0, 1'b1, 1, 0, 0, 1);
    @(negedge clk); cs_manual = 1'b1; cs_manual_level = 1'b0; #1;
    chk("R9", "manual cs low while idle", cs_n, 0);
    @(negedge clk); cs_manual_level = 1'b1; #1;
    chk("R9", "manual cs high", cs_n, 1);
    #1 clear_mon();
    send(32'h1234_5678);
    drop_tx();
    wait_done(1);
    chk("R9", "no cs fall under manual high", nfall, 0);
    chk("R9", "transfer still ran", rn, 1);
    @(negedge clk); cs_manual = 1'b0;
  endtask

  task automatic t_manual_start();
    cfg(3'd0, 1'b0, 1'b1, 1, 0, 0, 1);
    sw[0] = 32'h0F1E_2D3C;
    @(negedge clk); start_gate_en = 1'b1; tx_word = 32'hF0E1_D2C3; tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    #1;
    chk("R10", "no transfer before start", nfall, 0);
    chk("R10", "tx_ready held low", tx_ready, 0);
    @(negedge clk); start_cmd = 1'b1;
    @(negedge clk); start_cmd = 1'b0; #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    drop_tx();
    wait_done(1);
    chk("R10", "one transfer after start", rn, 1);
    chk("R10", "rx word after start", rcap[0], 32'h0F1E_2D3C);
    @(negedge clk); tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    #1;
    chk("R10", "start pulse not reused", nfall, 1);
    @(negedge clk); tx_valid = 1'b0; start_gate_en = 1'b0;
  endtask

  task automatic t_enable();
    cfg(3'd0, 1'b0, 1'b0, 1, 0, 0, 1);
    @(negedge clk); en = 1'b0; tx_word = 32'h5555_AAAA; tx_valid = 1'b1;
    repeat (30) @(negedge clk);
    #1;
    chk("R11", "no transfer while disabled", nfall, 0);
    chk("R11", "tx_ready low while disabled", tx_ready, 0);
    @(negedge clk); en = 1'b1; #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    drop_tx();
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk); #1;
    chk("R11", "cs high after disable", cs_n, 1);
    chk("R11", "sclk idle after disable", sclk, 0);
    chk("R11", "mosi low after disable", mosi, 0);
    repeat (200) @(negedge clk);
    chk("R11", "aborted word gives no rx", rn, 0);
    en = 1'b1;
  endtask

  initial begin
    en = 1'b0; cpol = 1'b0; cpha = 1'b0; cs_manual = 1'b0; cs_manual_level = 1'b1;
    start_gate_en = 1'b0; start_cmd = 1'b0; clk_div_sel = 3'd0;
    dly_lead = 8'd1; dly_word_gap = 8'd1; dly_cs_off = 8'd1; dly_cs_rest = 8'd1;
    tx_valid = 1'b0; tx_word = '0; miso = 1'b0;
    for (int i = 0; i < 4; i++) sw[i] = '0;
    repeat (5) @(negedge clk);
    #1;
    t_reset();
    t_mode0();
    t_mode3_b2b();
    t_release();
    t_rest();
    t_zero();
    t_slow();
    t_manual_cs();
    t_manual_start();
    t_enable();
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
    report();
    $finish;
  end

endmodule